// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Sequencer

This block turns a free-running oscillator into the timing backbone of a small processor core. It divides the oscillator by four into four non-overlapping phase strobes. One full rotation of the four phases is one instruction cycle. Each phase has a fixed job: the program counter advances as phase 1 begins. The word on the program-memory data bus is sampled as phase 4 begins. The instruction register takes that word as the next phase 1 begins. The data-memory read strobe is high in phase 2 and the write strobe is high in phase 4.

The fetch of one instruction overlaps the execution of the one before it, so straight-line code retires one instruction per instruction cycle. Decode, ALU and stack are outside the block. A branch request with a target address stands in for them. When a taken branch is seen at the end of phase 3, the target goes into the program counter as phase 4 begins. The instruction already fetched behind the branch is then squashed into a forced no-operation, so the branch costs one extra cycle. A divided clock-out pin follows the instruction cycle.

Top module: `quad_phase_sequencer`

## Requirements
- R1: `phase_o` is one-hot at all times and steps bit0 (Q1), bit1 (Q2), bit2 (Q3), bit3 (Q4), then back to bit0, advancing one bit per oscillator cycle.
- R2: `pmem_addr_o` shows the program counter. In straight-line code it rises by one at the start of each instruction cycle, and it is otherwise unchanged outside the start of Q1 and Q4.
- R3: The word read at the start of Q4 appears on `ir_o` from the next Q1 and is held for that whole instruction cycle; the instruction at address N executes in the cycle that fetches N+1.
- R4: Without branches, every instruction cycle after the first executes a real instruction (`exec_nop_o` low).
- R5: In an execute cycle that is not a forced no-operation, `dmem_rd_o` is high only during Q2 and `dmem_wr_o` only during Q4.
- R6: After a taken branch, the next instruction cycle has `exec_nop_o` high and `ir_o` equal to the NOP word (all zeros by default) while the target is fetched; the cycle after that executes the target instruction.
- R7: During a forced no-operation cycle, both data-memory strobes stay low and a branch request is ignored.
- R8: During and right after reset, the phase is Q1, the program counter is 0, `ir_o` holds the NOP word, `exec_nop_o` is high and `clkout_o` is high; the first execute cycle raises no strobe.
- R9: `clkout_o` is high during Q1 and Q2 and low during Q3 and Q4.
- R10: `branch_req_i` and `branch_tgt_i` are sampled only at the clock edge that ends Q3; the target is on `pmem_addr_o` from Q4. A request that is removed before that edge has no effect.
- R11: The program counter wraps from 2^ADDR_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator input |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pmem_addr_o | output | ADDR_W | Program-memory address (program counter) |
| pmem_data_i | input | INSTR_W | Program-memory read data |
| branch_req_i | input | 1 | Executing instruction requests a branch |
| branch_tgt_i | input | ADDR_W | Branch target address |
| phase_o | output | 4 | One-hot phase strobes, bit0 = Q1 |
| clkout_o | output | 1 | Oscillator divided by four |
| ir_o | output | INSTR_W | Instruction register |
| exec_nop_o | output | 1 | Current execute cycle is a forced no-operation |
| dmem_rd_o | output | 1 | Data-memory operand read strobe |
| dmem_wr_o | output | 1 | Data-memory destination write strobe |

## Verification
The hardest case to reach from the ports is a branch request arriving while the forced no-operation that follows an earlier branch is executing. It must not reload the counter and must not squash the target instruction. The bench reaches it by issuing a branch, then raising a second request with a different target across the Q3 edge of the squashed cycle. It then checks the address at Q4 and the instruction executed one cycle later. A second awkward case is a request that is held across the Q4 and Q1 edges but dropped before Q3 ends. The bench builds it by driving the input on falling edges tied to the phase strobes.

// File: rtl/qps_pkg.sv
package qps_pkg;
  localparam int unsigned PHASES  = 4;
  localparam int unsigned PHASE_W = $clog2(PHASES);

  typedef logic [PHASE_W-1:0] qps_phase_t;

  localparam qps_phase_t PH_Q1 = 2'd0;
  localparam qps_phase_t PH_Q2 = 2'd1;
  localparam qps_phase_t PH_Q3 = 2'd2;
  localparam qps_phase_t PH_Q4 = 2'd3;

  // clock-out level for a given phase: high in the first half of the cycle
  function automatic logic qps_clkout_level(input qps_phase_t ph);
    return (ph == PH_Q1) || (ph == PH_Q2);
  endfunction
endpackage

// File: rtl/qps_rst_sync.sv
module qps_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/qps_phase_gen.sv
module qps_phase_gen
  import qps_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  output qps_phase_t           phase_q_o,
  output logic [PHASES-1:0]    phase_o,
  output logic                 enter_q1_o,
  output logic                 enter_q4_o,
  output logic                 clkout_o
);
  qps_phase_t phase_q, phase_d;
  logic       clkout_q, clkout_d;

  always_comb begin
    phase_d  = phase_q + qps_phase_t'(1);
    clkout_d = qps_clkout_level(phase_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_Q1;
      clkout_q <= 1'b1;
    end else begin
      phase_q  <= phase_d;
      clkout_q <= clkout_d;
    end
  end

  for (genvar g = 0; g < PHASES; g++) begin : g_strobe
    assign phase_o[g] = (phase_q == qps_phase_t'(g));
  end

  assign phase_q_o  = phase_q;
  assign enter_q1_o = (phase_q == PH_Q4);
  assign enter_q4_o = (phase_q == PH_Q3);
  assign clkout_o   = clkout_q;

  assert_phase_onehot_R1: assert property (@(posedge clk_i)
    $countones(phase_o) == 1);
  assert_phase_q1_q2_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o[0] |=> phase_o[1]);
  assert_phase_q2_q3_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o[1] |=> phase_o[2]);
  assert_phase_q3_q4_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o[2] |=> phase_o[3]);
  assert_phase_q4_q1_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o[3] |=> phase_o[0]);
  assert_clkout_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o[0] || phase_o[1]) |-> clkout_q);
  assert_clkout_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o[2] || phase_o[3]) |-> !clkout_q);
endmodule

// File: rtl/qps_pc_unit.sv
module qps_pc_unit #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enter_q1_i,
  input  logic              enter_q4_i,
  input  logic              take_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam logic [ADDR_W-1:0] PC_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              hold_q, hold_d;
  logic              pc_en;

  always_comb begin
    pc_d   = pc_q;
    hold_d = hold_q;
    if (enter_q4_i && take_i) begin
      pc_d   = target_i;
      hold_d = 1'b1;
    end else if (enter_q1_i) begin
      if (!hold_q) pc_d = pc_q + PC_ONE;
      hold_d = 1'b0;
    end
  end

  assign pc_en = enter_q1_i | enter_q4_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      hold_q <= 1'b0;
    end else if (pc_en) begin
      pc_q   <= pc_d;
      hold_q <= hold_d;
    end
  end

  assign pc_o = pc_q;

  assert_pc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enter_q1_i && !hold_q) |=> (pc_q == ADDR_W'($past(pc_q) + PC_ONE)));
  assert_pc_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(enter_q1_i || enter_q4_i) |=> $stable(pc_q));
  assert_pc_target_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enter_q4_i && take_i) |=> (pc_q == $past(target_i)));
endmodule

// File: rtl/qps_exec_stage.sv
module qps_exec_stage #(
  parameter int unsigned       INSTR_W  = 14,
  parameter logic [INSTR_W-1:0] NOP_WORD = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enter_q1_i,
  input  logic               enter_q4_i,
  input  logic [INSTR_W-1:0] fetch_word_i,
  input  logic               branch_req_i,
  output logic               take_o,
  output logic [INSTR_W-1:0] ir_o,
  output logic               nop_o
);
  logic [INSTR_W-1:0] fetch_q, fetch_d;
  logic [INSTR_W-1:0] ir_q, ir_d;
  logic               nop_q, nop_d;
  logic               flush_q, flush_d;
  logic               take;

  // a forced no-operation cannot itself branch
  assign take = enter_q4_i && branch_req_i && !nop_q;

  always_comb begin
    fetch_d = fetch_q;
    flush_d = flush_q;
    ir_d    = ir_q;
    nop_d   = nop_q;
    if (enter_q4_i) begin
      fetch_d = fetch_word_i;
      flush_d = take;
    end
    if (enter_q1_i) begin
      ir_d    = flush_q ? NOP_WORD : fetch_q;
      nop_d   = flush_q;
      flush_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_q <= NOP_WORD;
      flush_q <= 1'b0;
    end else if (enter_q4_i || enter_q1_i) begin
      fetch_q <= fetch_d;
      flush_q <= flush_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q  <= NOP_WORD;
      nop_q <= 1'b1;
    end else if (enter_q1_i) begin
      ir_q  <= ir_d;
      nop_q <= nop_d;
    end
  end

  assign take_o = take;
  assign ir_o   = ir_q;
  assign nop_o  = nop_q;

  assert_ir_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enter_q1_i |=> $stable(ir_q));
  assert_flush_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enter_q4_i && branch_req_i && !nop_q) |=> ##1 (nop_q && ir_q == NOP_WORD));
  assert_no_flush_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enter_q4_i && !branch_req_i) |=> ##1 !nop_q);
  assert_nop_no_branch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enter_q4_i && nop_q) |=> ##1 !nop_q);
endmodule

// File: rtl/quad_phase_sequencer.sv
module quad_phase_sequencer
  import qps_pkg::*;
#(
  parameter int unsigned        ADDR_W      = 11,
  parameter int unsigned        INSTR_W     = 14,
  parameter logic [INSTR_W-1:0] NOP_WORD    = '0,
  parameter int unsigned        SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [ADDR_W-1:0]  pmem_addr_o,
  input  logic [INSTR_W-1:0] pmem_data_i,
  input  logic               branch_req_i,
  input  logic [ADDR_W-1:0]  branch_tgt_i,
  output logic [PHASES-1:0]  phase_o,
  output logic               clkout_o,
  output logic [INSTR_W-1:0] ir_o,
  output logic               exec_nop_o,
  output logic               dmem_rd_o,
  output logic               dmem_wr_o
);
  logic       rst_n;
  qps_phase_t phase_q;
  logic       enter_q1, enter_q4;
  logic       take;
  logic       nop;

  qps_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  qps_phase_gen u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .phase_q_o  (phase_q),
    .phase_o    (phase_o),
    .enter_q1_o (enter_q1),
    .enter_q4_o (enter_q4),
    .clkout_o   (clkout_o)
  );

  qps_pc_unit #(.ADDR_W(ADDR_W)) u_pc (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .enter_q1_i (enter_q1),
    .enter_q4_i (enter_q4),
    .take_i     (take),
    .target_i   (branch_tgt_i),
    .pc_o       (pmem_addr_o)
  );

  qps_exec_stage #(.INSTR_W(INSTR_W), .NOP_WORD(NOP_WORD)) u_exec (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .enter_q1_i   (enter_q1),
    .enter_q4_i   (enter_q4),
    .fetch_word_i (pmem_data_i),
    .branch_req_i (branch_req_i),
    .take_o       (take),
    .ir_o         (ir_o),
    .nop_o        (nop)
  );

  assign exec_nop_o = nop;
  assign dmem_rd_o  = (phase_q == PH_Q2) && !nop;
  assign dmem_wr_o  = (phase_q == PH_Q4) && !nop;

  assert_rd_single_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    dmem_rd_o |=> (!dmem_rd_o && !dmem_wr_o));
  assert_wr_after_rd_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    dmem_rd_o |=> ##1 dmem_wr_o);
  assert_nop_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    exec_nop_o |-> !(dmem_rd_o || dmem_wr_o));
endmodule

// File: tb/quad_phase_sequencer_tb.sv
module quad_phase_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int IW = 14;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] pmem_addr;
  logic [IW-1:0] pmem_data;
  logic          br_req;
  logic [AW-1:0] br_tgt;
  logic [3:0]    phase;
  logic          clkout;
  logic [IW-1:0] ir;
  logic          exec_nop;
  logic          rd, wr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [IW-1:0] pm(input logic [AW-1:0] a);
    return {3'b101, a};
  endfunction

  always_comb pmem_data = pm(pmem_addr);

  quad_phase_sequencer dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .pmem_addr_o  (pmem_addr),
    .pmem_data_i  (pmem_data),
    .branch_req_i (br_req),
    .branch_tgt_i (br_tgt),
    .phase_o      (phase),
    .clkout_o     (clkout),
    .ir_o         (ir),
    .exec_nop_o   (exec_nop),
    .dmem_rd_o    (rd),
    .dmem_wr_o    (wr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // advance at least one falling edge, stop on the one whose phase is k
  task automatic wait_phase(input int k);
    do @(negedge clk); while (phase !== (4'b1 << k));
  endtask

  task automatic do_reset();
    rst_n  = 1'b0;
    br_req = 1'b0;
    br_tgt = '0;
    repeat (4) @(negedge clk);
    chk("R8", "phase in reset", phase, 4'b0001);
    chk("R8", "pc in reset", pmem_addr, 0);
    chk("R8", "ir in reset", ir, 0);
    chk("R8", "nop in reset", exec_nop, 1);
    chk("R8", "clkout in reset", clkout, 1);
    rst_n = 1'b1;
  endtask

  task automatic t_rotation();
    wait_phase(0);
    for (int k = 0; k < 8; k++) begin
      chk("R1", "phase step", phase, 4'b1 << (k % 4));
      chk("R9", "clkout level", clkout, ((k % 4) < 2) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  // straight-line run from reset: cycle n fetches n and executes n-1
  task automatic t_straight();
    do_reset();
    for (int n = 0; n < 6; n++) begin
      wait_phase(1);
      chk("R2", "fetch addr", pmem_addr, n);
      chk("R4", "nop flag", exec_nop, (n == 0) ? 1 : 0);
      chk("R3", "ir word", ir, (n == 0) ? 0 : pm(AW'(n - 1)));
      chk("R5", "rd in Q2", rd, (n == 0) ? 0 : 1);
      chk("R5", "wr in Q2", wr, 0);
      wait_phase(2);
      chk("R5", "rd in Q3", rd, 0);
      wait_phase(3);
      chk("R5", "wr in Q4", wr, (n == 0) ? 0 : 1);
      chk("R8", "rd in Q4", rd, 0);
      chk("R3", "ir held to Q4", ir, (n == 0) ? 0 : pm(AW'(n - 1)));
    end
  endtask

  // continues from the current cycle: at Q2 of a normal execute cycle
  task automatic t_branch(input logic [AW-1:0] tgt, input logic second);
    logic [AW-1:0] a;
    wait_phase(1);
    a      = pmem_addr;
    br_req = 1'b1;
    br_tgt = tgt;
    wait_phase(3);
    chk("R10", "target at Q4", pmem_addr, tgt);
    br_req = 1'b0;
    wait_phase(1);
    chk("R6", "squash flag", exec_nop, 1);
    chk("R6", "squash ir", ir, 0);
    chk("R6", "target fetch", pmem_addr, tgt);
    chk("R7", "rd in squash", rd, 0);
    if (second) begin
      br_req = 1'b1;
      br_tgt = tgt ^ AW'(5);
    end
    wait_phase(3);
    chk("R7", "wr in squash", wr, 0);
    chk("R7", "late branch ignored", pmem_addr, tgt);
    br_req = 1'b0;
    wait_phase(1);
    chk("R6", "target executes", ir, pm(tgt));
    chk("R6", "flag clear", exec_nop, 0);
    chk("R11", "next fetch", pmem_addr, AW'(tgt + 1'b1));
    chk("R2", "squashed addr unused", (ir == pm(AW'(a))) ? 1 : 0, 0);
  endtask

  task automatic t_early_drop();
    logic [AW-1:0] a;
    wait_phase(3);
    br_req = 1'b1;
    br_tgt = 11'h155;
    wait_phase(1);
    a      = pmem_addr;
    br_req = 1'b0;
    wait_phase(3);
    chk("R10", "early request ignored", pmem_addr, a);
    wait_phase(1);
    chk("R10", "no squash", exec_nop, 0);
    chk("R10", "sequential", pmem_addr, AW'(a + 1'b1));
  endtask

  initial begin
    rst_n  = 1'b0;
    br_req = 1'b0;
    br_tgt = '0;
    t_straight();
    t_rotation();
    t_branch(11'h234, 1'b0);
    t_branch(11'h0f0, 1'b1);
    t_early_drop();
    t_branch(11'h7ff, 1'b0);
    wait_phase(1);
    chk("R11", "wrapped ir", ir, pm(11'h000));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule